// File: doc/BRIEF.md
# Interleaved Packed Operand Memory

This block holds a small 30-location data memory for a decimal-style processor core. Each location holds a 10-bit value. Storage is ten rows of three slots each. Rows are interleaved: location L sits in row L mod 10 at slot L div 10. Within a row, slot 0 is packed in the most significant position, slot 1 in the middle and slot 2 in the least significant position.

The core issues a one-cycle request carrying a raw operand address from 0 to 99, a write flag, write data and the current value of its index register. The block first resolves an effective address. A raw address below 30 is used as is. A raw address from 50 to 79 is rebased to 0 and added to the index value. Any other result is an address error.

For a valid request, the block unpacks the selected row one slot per cycle. A fetch finishes as soon as its slot has been extracted, so locations 0 to 9 form a fast region. A store always unpacks the whole row, replaces one slot, repacks the row and writes it back, and so takes a fixed time. The last resolved effective address stays on an output, so the core can derive its next program counter from it.

Top module: `pmem_top`

## Requirements
- R1: A raw address from 0 to 29 is used unchanged as the effective address, and `ea_o` shows it once the access completes.
- R2: A raw address from 50 to 79 gives an effective address equal to (raw − 50) plus `breg_i`.
- R3: A fetch of effective address E raises `done_o` after 1 + (E div 10) clock edges, counting the edge that accepts the request. Locations 0–9 take 1 edge, 10–19 take 2 and 20–29 take 3.
- R4: A valid store raises `done_o` after 4 edges, for every effective address.
- R5: A store to E changes only location E. Locations E mod 10, E mod 10 + 10 and E mod 10 + 20 that share its row keep their values.
- R6: A fetch returns on `rdata_o` the last value stored at its effective address. Every location reads 0 after reset.
- R7: A raw address from 30 to 49 or above 79, or an indexed effective address above 29, completes after 1 edge with `done_o` and `aerr_o` both high. It writes nothing and leaves `ea_o` unchanged.
- R8: `ea_o` changes only when a valid request is accepted. It resets to 0.
- R9: A request that arrives while an access is in progress is ignored.
- R10: `done_o` is a single-cycle pulse per access, and `aerr_o` is high only together with `done_o`. Both reset low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Request strobe, accepted only when idle |
| wr_i | input | 1 | 1 = store, 0 = fetch |
| addr_i | input | 7 | Raw operand address, 0..99 |
| wdata_i | input | 10 | Store data |
| breg_i | input | B_W | Index register value |
| rdata_o | output | 10 | Fetched value, updated by fetches |
| done_o | output | 1 | Access complete pulse |
| aerr_o | output | 1 | Address error, valid with done_o |
| ea_o | output | 5 | Last resolved effective address |

## Verification
Writes go to three locations that share one row (5, 15 and 25). Reading all three back tells a correct read-modify-write apart from one that overwrites neighbours or misplaces a slot in the packing. Fetches are spread over the three slot positions, so the measured latency confirms the interleave: row = units digit, slot = tens digit. Indexed accesses hit the same cells as direct ones, and each kind of address error is tried (raw gap, raw above 79, index overflow past 29), followed by reads that show no write took place. A request issued during a slow fetch checks that busy requests are dropped.

// File: rtl/pmem_pkg.sv
package pmem_pkg;
    localparam int ROWS      = 10;
    localparam int SLOTS     = 3;
    localparam int DW        = 10;
    localparam int AW        = 7;
    localparam int LOCS      = ROWS * SLOTS;
    localparam int EAW       = $clog2(LOCS);
    localparam int RW        = $clog2(ROWS);
    localparam int SW        = $clog2(SLOTS);
    localparam int IDX_BASE  = 50;
    localparam int IDX_LAST  = IDX_BASE + LOCS - 1;
    localparam int ROWBITS   = SLOTS * DW;

    typedef logic [DW-1:0]      word_t;
    typedef logic [ROWBITS-1:0] row_t;

    typedef struct packed {
        logic           err;
        logic [EAW-1:0] ea;
        logic [RW-1:0]  row;
        logic [SW-1:0]  slot;
    } resolve_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_UNPACK = 2'd1,
        ST_WRITE  = 2'd2
    } seq_state_e;

    // slot 0 occupies the most significant field of a row
    function automatic word_t slot_of(row_t r, int s);
        return r[(SLOTS-1-s)*DW +: DW];
    endfunction
endpackage

// File: rtl/pmem_resolve.sv
module pmem_resolve
    import pmem_pkg::*;
#(
    parameter int B_W = 10
) (
    input  logic [AW-1:0]  addr_i,
    input  logic [B_W-1:0] breg_i,
    output resolve_t       res_o
);
    localparam int FW = ((B_W > AW) ? B_W : AW) + 1;

    logic [FW-1:0] full;
    logic          raw_ok;

    always_comb begin
        full   = '0;
        raw_ok = 1'b0;
        if (int'(addr_i) < LOCS) begin
            full   = FW'(addr_i);
            raw_ok = 1'b1;
        end else if (int'(addr_i) >= IDX_BASE && int'(addr_i) <= IDX_LAST) begin
            full   = FW'(addr_i) - FW'(IDX_BASE) + FW'(breg_i);
            raw_ok = 1'b1;
        end
        res_o.err = !raw_ok || (full >= FW'(LOCS));
        res_o.ea  = res_o.err ? '0 : full[EAW-1:0];
        res_o.row = RW'(res_o.ea % ROWS);
        res_o.slot = SW'(res_o.ea / ROWS);
    end
endmodule

// File: rtl/pmem_rows.sv
module pmem_rows
    import pmem_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [RW-1:0] rd_row_i,
    output row_t          rd_data_o,
    input  logic          we_i,
    input  logic [RW-1:0] wr_row_i,
    input  row_t          wr_data_o_i
);
    row_t mem [ROWS];

    generate
        for (genvar g = 0; g < ROWS; g++) begin : g_row
            always_ff @(posedge clk) begin
                if (rst)
                    mem[g] <= '0;
                else if (we_i && wr_row_i == RW'(g))
                    mem[g] <= wr_data_o_i;
            end
        end
    endgenerate

    always_comb begin
        rd_data_o = '0;
        if (int'(rd_row_i) < ROWS)
            rd_data_o = mem[rd_row_i];
    end

    p_write_row_range_r5: assert property (@(posedge clk) disable iff (rst)
        we_i |-> (int'(wr_row_i) < ROWS));
endmodule

// File: rtl/pmem_seq.sv
module pmem_seq
    import pmem_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           req_i,
    input  logic           wr_i,
    input  word_t          wdata_i,
    input  resolve_t       res_i,
    input  row_t           row_i,
    output logic           we_o,
    output logic [RW-1:0]  wr_row_o,
    output row_t           wr_row_data_o,
    output word_t          rdata_o,
    output logic           done_o,
    output logic           aerr_o,
    output logic [EAW-1:0] ea_o
);
    seq_state_e    state;
    logic [SW-1:0] step;
    logic [SW-1:0] tgt_slot;
    logic [RW-1:0] tgt_row;
    logic          is_wr;
    word_t         wd;
    row_t          shreg;
    word_t         upk [SLOTS];
    word_t         cur;
    logic          accept;

    assign accept = (state == ST_IDLE) && req_i;
    assign cur    = slot_of(shreg, 0);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            step     <= '0;
            tgt_slot <= '0;
            tgt_row  <= '0;
            is_wr    <= 1'b0;
            wd       <= '0;
            shreg    <= '0;
            rdata_o  <= '0;
            done_o   <= 1'b0;
            aerr_o   <= 1'b0;
            ea_o     <= '0;
            for (int s = 0; s < SLOTS; s++) upk[s] <= '0;
        end else begin
            done_o <= 1'b0;
            aerr_o <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (req_i) begin
                        if (res_i.err) begin
                            done_o <= 1'b1;
                            aerr_o <= 1'b1;
                        end else begin
                            ea_o     <= res_i.ea;
                            tgt_slot <= res_i.slot;
                            tgt_row  <= res_i.row;
                            is_wr    <= wr_i;
                            wd       <= wdata_i;
                            upk[0]   <= slot_of(row_i, 0);
                            shreg    <= row_i << DW;
                            if (!wr_i && res_i.slot == '0) begin
                                rdata_o <= slot_of(row_i, 0);
                                done_o  <= 1'b1;
                            end else begin
                                state <= ST_UNPACK;
                                step  <= SW'(1);
                            end
                        end
                    end
                end
                ST_UNPACK: begin
                    upk[step] <= cur;
                    shreg     <= shreg << DW;
                    if (!is_wr && step == tgt_slot) begin
                        rdata_o <= cur;
                        done_o  <= 1'b1;
                        state   <= ST_IDLE;
                    end else if (int'(step) == SLOTS-1) begin
                        state <= ST_WRITE;
                    end else begin
                        step <= step + SW'(1);
                    end
                end
                ST_WRITE: begin
                    done_o <= 1'b1;
                    state  <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign we_o     = (state == ST_WRITE);
    assign wr_row_o = tgt_row;

    always_comb begin
        wr_row_data_o = '0;
        for (int s = 0; s < SLOTS; s++)
            wr_row_data_o[(SLOTS-1-s)*DW +: DW] = (tgt_slot == SW'(s)) ? wd : upk[s];
    end

    p_err_with_done_r10: assert property (@(posedge clk) disable iff (rst)
        aerr_o |-> done_o);

    p_error_one_edge_r7: assert property (@(posedge clk) disable iff (rst)
        (accept && res_i.err) |=> (done_o && aerr_o && $stable(ea_o)));

    p_slot0_fast_r3: assert property (@(posedge clk) disable iff (rst)
        (accept && !res_i.err && !wr_i && res_i.slot == '0) |=> (done_o && !aerr_o));

    p_store_done_after_write_r4: assert property (@(posedge clk) disable iff (rst)
        we_o |=> (done_o && !aerr_o));

    p_ea_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !(accept && !res_i.err) |=> $stable(ea_o));

    p_busy_no_err_r9: assert property (@(posedge clk) disable iff (rst)
        (state != ST_IDLE) |=> !aerr_o);
endmodule

// File: rtl/pmem_top.sv
module pmem_top
    import pmem_pkg::*;
#(
    parameter int B_W = 10
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            req_i,
    input  logic            wr_i,
    input  logic [6:0]      addr_i,
    input  logic [9:0]      wdata_i,
    input  logic [B_W-1:0]  breg_i,
    output logic [9:0]      rdata_o,
    output logic            done_o,
    output logic            aerr_o,
    output logic [4:0]      ea_o
);
    resolve_t      res;
    row_t          rd_row_data;
    row_t          wr_row_data;
    logic          we;
    logic [RW-1:0] wr_row;

    pmem_resolve #(.B_W(B_W)) u_resolve (
        .addr_i (addr_i),
        .breg_i (breg_i),
        .res_o  (res)
    );

    pmem_rows u_rows (
        .clk         (clk),
        .rst         (rst),
        .rd_row_i    (res.row),
        .rd_data_o   (rd_row_data),
        .we_i        (we),
        .wr_row_i    (wr_row),
        .wr_data_o_i (wr_row_data)
    );

    pmem_seq u_seq (
        .clk           (clk),
        .rst           (rst),
        .req_i         (req_i),
        .wr_i          (wr_i),
        .wdata_i       (wdata_i),
        .res_i         (res),
        .row_i         (rd_row_data),
        .we_o          (we),
        .wr_row_o      (wr_row),
        .wr_row_data_o (wr_row_data),
        .rdata_o       (rdata_o),
        .done_o        (done_o),
        .aerr_o        (aerr_o),
        .ea_o          (ea_o)
    );

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        (done_o && !req_i) |=> !done_o);
endmodule

// File: tb/pmem_top_tb.sv
module pmem_top_tb;
    logic       clk = 1'b0;
    logic       rst;
    logic       req_i = 1'b0;
    logic       wr_i = 1'b0;
    logic [6:0] addr_i = '0;
    logic [9:0] wdata_i = '0;
    logic [9:0] breg_i = '0;
    logic [9:0] rdata_o;
    logic       done_o;
    logic       aerr_o;
    logic [4:0] ea_o;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    pmem_top #(.B_W(10)) u_dut (
        .clk(clk), .rst(rst), .req_i(req_i), .wr_i(wr_i), .addr_i(addr_i),
        .wdata_i(wdata_i), .breg_i(breg_i), .rdata_o(rdata_o),
        .done_o(done_o), .aerr_o(aerr_o), .ea_o(ea_o)
    );

    typedef struct packed {
        logic       wr;
        logic [6:0] addr;
        logic [9:0] b;
        logic [9:0] wd;
        logic [9:0] erd;
        logic [2:0] lat;
        logic       err;
        logic [4:0] ea;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 7'd5,  10'd0,  10'd111, 10'd0,   3'd4, 1'b0, 5'd5},   // R4 store row5 slot0
        '{1'b1, 7'd15, 10'd0,  10'd222, 10'd0,   3'd4, 1'b0, 5'd15},  // R4 slot1
        '{1'b1, 7'd25, 10'd0,  10'd333, 10'd0,   3'd4, 1'b0, 5'd25},  // R4 slot2
        '{1'b0, 7'd5,  10'd0,  10'd0,   10'd111, 3'd1, 1'b0, 5'd5},   // R3 fast
        '{1'b0, 7'd15, 10'd0,  10'd0,   10'd222, 3'd2, 1'b0, 5'd15},
        '{1'b0, 7'd25, 10'd0,  10'd0,   10'd333, 3'd3, 1'b0, 5'd25},
        '{1'b1, 7'd52, 10'd13, 10'd444, 10'd0,   3'd4, 1'b0, 5'd15},  // R2 indexed store
        '{1'b0, 7'd5,  10'd0,  10'd0,   10'd111, 3'd1, 1'b0, 5'd5},   // R5 neighbour
        '{1'b0, 7'd25, 10'd0,  10'd0,   10'd333, 3'd3, 1'b0, 5'd25},  // R5 neighbour
        '{1'b0, 7'd65, 10'd0,  10'd0,   10'd444, 3'd2, 1'b0, 5'd15},  // R2 indexed fetch
        '{1'b0, 7'd40, 10'd0,  10'd0,   10'd0,   3'd1, 1'b1, 5'd15},  // R7 raw gap
        '{1'b1, 7'd85, 10'd0,  10'd555, 10'd0,   3'd1, 1'b1, 5'd15},  // R7 raw above 79
        '{1'b0, 7'd79, 10'd1,  10'd0,   10'd0,   3'd1, 1'b1, 5'd15},  // R7 ea 30
        '{1'b0, 7'd29, 10'd0,  10'd0,   10'd0,   3'd3, 1'b0, 5'd29},  // R6 reset zero
        '{1'b0, 7'd50, 10'd29, 10'd0,   10'd0,   3'd3, 1'b0, 5'd29},  // R2 top edge
        '{1'b1, 7'd79, 10'd0,  10'd666, 10'd0,   3'd4, 1'b0, 5'd29},
        '{1'b1, 7'd79, 10'd1,  10'd777, 10'd0,   3'd1, 1'b1, 5'd29},  // R7 no write
        '{1'b0, 7'd29, 10'd0,  10'd0,   10'd666, 3'd3, 1'b0, 5'd29},
        '{1'b0, 7'd9,  10'd0,  10'd0,   10'd0,   3'd1, 1'b0, 5'd9}    // R5 row9 slot0
    };

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // issue one request, return measured latency and sampled outputs
    task automatic access(input logic w, input int a, input int b, input int d,
                          output int lat, output int rd, output int er, output int ea);
        int got;
        @(negedge clk);
        req_i = 1'b1; wr_i = w; addr_i = 7'(a); breg_i = 10'(b); wdata_i = 10'(d);
        got = 0; lat = 0;
        for (int i = 1; i <= 20 && got == 0; i++) begin
            @(negedge clk);
            req_i = 1'b0;
            if (done_o) begin got = 1; lat = i; end
        end
        rd = int'(rdata_o); er = int'(aerr_o); ea = int'(ea_o);
        if (got == 0) chk("R3 done never seen", 0, 1);
        @(negedge clk);
        chk("R10 done single pulse", int'(done_o), 0);
        chk("R10 aerr low after done", int'(aerr_o), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int lat, rd, er, ea;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // reset state: R8 R10 R6
        chk("R10 reset done", int'(done_o), 0);
        chk("R10 reset aerr", int'(aerr_o), 0);
        chk("R8 reset ea", int'(ea_o), 0);
        chk("R6 reset rdata", int'(rdata_o), 0);

        for (int v = 0; v < NV; v++) begin
            access(VECS[v].wr, int'(VECS[v].addr), int'(VECS[v].b), int'(VECS[v].wd),
                   lat, rd, er, ea);
            chk($sformatf("R3/R4/R7 latency vec %0d", v), lat, int'(VECS[v].lat));
            chk($sformatf("R7 aerr vec %0d", v), er, int'(VECS[v].err));
            chk($sformatf("R1/R2/R8 ea vec %0d", v), ea, int'(VECS[v].ea));
            if (!VECS[v].wr && !VECS[v].err)
                chk($sformatf("R6 rdata vec %0d", v), rd, int'(VECS[v].erd));
        end

        // R9: store to 5 issued while a slot2 fetch is busy must be dropped
        begin
            int dn = 0;
            @(negedge clk);
            req_i = 1'b1; wr_i = 1'b0; addr_i = 7'd25; breg_i = '0;
            @(negedge clk);
            wr_i = 1'b1; addr_i = 7'd5; wdata_i = 10'd777;
            if (done_o) dn++;
            @(negedge clk);
            req_i = 1'b0;
            if (done_o) dn++;
            for (int i = 0; i < 6; i++) begin
                @(negedge clk);
                if (done_o) dn++;
            end
            chk("R9 one completion only", dn, 1);
            chk("R9 busy fetch data", int'(rdata_o), 333);
            chk("R9 ea from first request", int'(ea_o), 25);
        end
        access(1'b0, 5, 0, 0, lat, rd, er, ea);
        chk("R9 location 5 untouched", rd, 111);
        chk("R3 fetch 5 latency", lat, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule